// File: doc/BRIEF.md
# Two-Wire Identification Memory Slave

This block is a slave on a two-wire serial bus. It presents a 128-byte identification memory to a host at the 8-bit device byte 0xA0 (write) and 0xA1 (read). The memory is a register array that comes out of reset with its identity bytes. The block then fills in two checksum bytes itself. It never stores them as constants.

A host sets the byte pointer by writing one address byte after a write-direction device byte. It then reads a run of bytes from that point, or writes new values into the serial-number, date-code and vendor fields. Any write inside the upper checksum range makes the block recompute that checksum.

The open-drain bus is seen as two input lines, SCL and SDA. The block has one output, which pulls SDA low when set. Both lines pass through a synchronizer and are sampled by a system clock that runs at least ten times faster than SCL.

Top module: `idb_serial_id`

## Requirements
- R1: Bus bytes travel MSB first, and an ACK means SDA is held low for the ninth SCL pulse. A device byte whose upper seven bits equal 0x50 gets an ACK. Any other device byte gets no ACK, and the block leaves SDA undriven until the next START.
- R2: Out of reset the array holds these values. Byte a in 0..62 is (7*a+3) mod 256. Byte a in 64..94 is a XOR 0xA5. Bytes 96..127 are 0x00.
- R3: Byte 63 holds the low 8 bits of the sum of bytes 0..62. It is in place before the block acknowledges any access.
- R4: Byte 95 holds the low 8 bits of the sum of bytes 64..94. It is recomputed after any write that lands in 64..94.
- R5: The byte that follows a 0xA0 device byte loads the pointer from its low seven bits, and bit 7 is ignored. A read that starts after a START or a repeated START begins at the pointer. The pointer keeps its value across STOP and across traffic sent to other device addresses.
- R6: Each byte read advances the pointer, and the pointer wraps from 127 to 0. A NACK from the master ends the read, and SDA is then released.
- R7: Data bytes written to 68..91 or 96..127 are stored. Data bytes written to any other address, including 63 and 95, are acknowledged but discarded. The pointer advances after every data byte either way.
- R8: The SDA drive (sda_oe = 1 pulls low) is 0 out of reset. It changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A full 128-byte dump from address 0 is compared with values computed from the seed formula and the checksum rule. This separates a wrong seed byte from a wrong or misplaced checksum. A short read from 126 shows whether the pointer wraps, and a single-byte read after a foreign-address transfer shows whether the pointer survived that traffic. The foreign device byte is followed by 0xFF, so any stray pull-down on SDA becomes visible. Writes inside and outside the writable windows, including both checksum slots, are read back. This separates stored data from discarded data and confirms that byte 95 tracks the new contents while byte 63 does not change. A pointer byte with bit 7 set checks that only the low seven bits are used.

// File: rtl/idb_pkg.sv
package idb_pkg;

  localparam int unsigned MEM_BYTES = 128;
  localparam int unsigned AW        = $clog2(MEM_BYTES);

  // checksum ranges and their result slots
  localparam int unsigned LO_FIRST  = 0;
  localparam int unsigned LO_LAST   = 62;
  localparam int unsigned LO_SUM    = 63;
  localparam int unsigned HI_FIRST  = 64;
  localparam int unsigned HI_LAST   = 94;
  localparam int unsigned HI_SUM    = 95;

  // host-writable windows: serial number + date code, vendor area
  localparam int unsigned SERIAL_FIRST = 68;
  localparam int unsigned DATE_LAST    = 91;
  localparam int unsigned VENDOR_FIRST = 96;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_DEV,
    LK_DEV_ACK,
    LK_PTR,
    LK_PTR_ACK,
    LK_WDAT,
    LK_WDAT_ACK,
    LK_RDAT,
    LK_RACK
  } link_state_e;

  function automatic logic [7:0] seed_byte(int unsigned a);
    if (a <= LO_LAST)                       return 8'(a * 7 + 3);
    else if (a >= HI_FIRST && a <= HI_LAST) return 8'(a) ^ 8'hA5;
    else                                    return 8'h00;
  endfunction

  function automatic logic host_writable(logic [AW-1:0] a);
    int unsigned u;
    u = 32'(a);
    return (u >= SERIAL_FIRST && u <= DATE_LAST) || (u >= VENDOR_FIRST);
  endfunction

endpackage

// File: rtl/idb_sync.sv
module idb_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/idb_store.sv
module idb_store
  import idb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [7:0]    din_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [7:0]    din_b,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);

  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < MEM_BYTES; i++) mem[i] <= seed_byte(i);
    end else begin
      if (we_a) mem[addr_a] <= din_a;
      if (we_b) mem[addr_b] <= din_b;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/idb_csum.sv
module idb_csum
  import idb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_dirty,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          ready
);

  logic          busy, busy_n;
  logic          sel_hi, sel_hi_n;
  logic [AW-1:0] addr, addr_n;
  logic [7:0]    acc, acc_n;
  logic          need_lo, need_lo_n;
  logic          need_hi, need_hi_n;
  logic          rdy, rdy_n;
  logic [AW-1:0] last;

  assign last = sel_hi ? AW'(HI_LAST) : AW'(LO_LAST);

  always_comb begin
    busy_n    = busy;
    sel_hi_n  = sel_hi;
    addr_n    = addr;
    acc_n     = acc;
    need_lo_n = need_lo;
    need_hi_n = need_hi;
    rdy_n     = rdy;
    wr_en     = 1'b0;
    if (!busy) begin
      if (need_lo) begin
        busy_n    = 1'b1;
        sel_hi_n  = 1'b0;
        addr_n    = AW'(LO_FIRST);
        acc_n     = '0;
        need_lo_n = 1'b0;
      end else if (need_hi) begin
        busy_n    = 1'b1;
        sel_hi_n  = 1'b1;
        addr_n    = AW'(HI_FIRST);
        acc_n     = '0;
        need_hi_n = 1'b0;
      end else begin
        rdy_n = 1'b1;
      end
    end else begin
      acc_n = acc + rd_data;
      if (addr == last) begin
        wr_en  = 1'b1;
        busy_n = 1'b0;
      end else begin
        addr_n = addr + 1'b1;
      end
    end
    if (hi_dirty) need_hi_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sel_hi  <= 1'b0;
      addr    <= '0;
      acc     <= '0;
      need_lo <= 1'b1;
      need_hi <= 1'b1;
      rdy     <= 1'b0;
    end else begin
      busy    <= busy_n;
      sel_hi  <= sel_hi_n;
      addr    <= addr_n;
      acc     <= acc_n;
      need_lo <= need_lo_n;
      need_hi <= need_hi_n;
      rdy     <= rdy_n;
    end
  end

  assign rd_addr = addr;
  assign wr_addr = sel_hi ? AW'(HI_SUM) : AW'(LO_SUM);
  assign wr_data = acc + rd_data;
  assign ready   = rdy;

endmodule

// File: rtl/idb_link.sv
module idb_link
  import idb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl,
  input  logic          sda,
  input  logic          ready,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          hi_dirty,
  output logic          sda_oe
);

  link_state_e   st, st_n;
  logic [7:0]    sh, sh_n;
  logic [3:0]    cnt, cnt_n;
  logic [AW-1:0] ptr, ptr_n;
  logic          oe, oe_n;
  logic          rnw, rnw_n;
  logic          mack, mack_n;
  logic          scl_q, sda_q;
  logic          scl_rise, scl_fall, is_start, is_stop;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign is_start = scl & scl_q & sda_q & ~sda;
  assign is_stop  = scl & scl_q & ~sda_q & sda;

  always_comb begin
    st_n     = st;
    sh_n     = sh;
    cnt_n    = cnt;
    ptr_n    = ptr;
    oe_n     = oe;
    rnw_n    = rnw;
    mack_n   = mack;
    wr_en    = 1'b0;
    hi_dirty = 1'b0;
    if (is_start) begin
      st_n  = LK_DEV;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (is_stop) begin
      st_n = LK_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st)
        LK_DEV, LK_PTR, LK_WDAT: begin
          if (scl_rise) begin
            sh_n  = {sh[6:0], sda};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            if (st == LK_DEV) begin
              if (sh[7:1] == DEV_ADDR && ready) begin
                oe_n  = 1'b1;
                rnw_n = sh[0];
                st_n  = LK_DEV_ACK;
              end else begin
                st_n = LK_IDLE;
              end
            end else if (st == LK_PTR) begin
              ptr_n = sh[AW-1:0];
              oe_n  = 1'b1;
              st_n  = LK_PTR_ACK;
            end else begin
              wr_en    = host_writable(ptr);
              hi_dirty = host_writable(ptr) && (32'(ptr) <= HI_LAST);
              ptr_n    = ptr + 1'b1;
              oe_n     = 1'b1;
              st_n     = LK_WDAT_ACK;
            end
          end
        end
        LK_DEV_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rnw) begin
              st_n  = LK_RDAT;
              sh_n  = rd_data;
              oe_n  = ~rd_data[7];
              ptr_n = ptr + 1'b1;
            end else begin
              st_n = LK_PTR;
              oe_n = 1'b0;
            end
          end
        end
        LK_PTR_ACK, LK_WDAT_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            oe_n  = 1'b0;
            st_n  = LK_WDAT;
          end
        end
        LK_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_n = 1'b0;
              st_n = LK_RACK;
            end else begin
              sh_n = {sh[6:0], 1'b0};
              oe_n = ~sh[6];
            end
          end
        end
        LK_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (mack) begin
              st_n  = LK_RDAT;
              sh_n  = rd_data;
              oe_n  = ~rd_data[7];
              ptr_n = ptr + 1'b1;
            end else begin
              st_n = LK_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LK_IDLE;
      sh    <= '0;
      cnt   <= '0;
      ptr   <= '0;
      oe    <= 1'b0;
      rnw   <= 1'b0;
      mack  <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      st    <= st_n;
      sh    <= sh_n;
      cnt   <= cnt_n;
      ptr   <= ptr_n;
      oe    <= oe_n;
      rnw   <= rnw_n;
      mack  <= mack_n;
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign ptr_o   = ptr;
  assign wr_addr = ptr;
  assign wr_data = sh;
  assign sda_oe  = oe;

endmodule

// File: rtl/idb_serial_id.sv
module idb_serial_id
  import idb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic [1:0]    rst_pipe;
  logic          rst_q;
  logic [1:0]    bus_s;
  logic          scl_s, sda_s;
  logic          cs_ready, cs_we, host_we, hi_dirty;
  logic [AW-1:0] cs_addr, cs_raddr, host_addr, ptr;
  logic [7:0]    cs_data, cs_rdata, host_data, ptr_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  idb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     ({scl_i, sda_i}),
    .q     (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  idb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk      (clk),
    .rst_n    (rst_q),
    .scl      (scl_s),
    .sda      (sda_s),
    .ready    (cs_ready),
    .rd_data  (ptr_rdata),
    .ptr_o    (ptr),
    .wr_en    (host_we),
    .wr_addr  (host_addr),
    .wr_data  (host_data),
    .hi_dirty (hi_dirty),
    .sda_oe   (sda_oe)
  );

  idb_csum u_csum (
    .clk      (clk),
    .rst_n    (rst_q),
    .hi_dirty (hi_dirty),
    .rd_data  (cs_rdata),
    .rd_addr  (cs_raddr),
    .wr_en    (cs_we),
    .wr_addr  (cs_addr),
    .wr_data  (cs_data),
    .ready    (cs_ready)
  );

  idb_store u_store (
    .clk     (clk),
    .rst_n   (rst_q),
    .we_a    (host_we),
    .addr_a  (host_addr),
    .din_a   (host_data),
    .we_b    (cs_we),
    .addr_b  (cs_addr),
    .din_b   (cs_data),
    .raddr_a (ptr),
    .rdata_a (ptr_rdata),
    .raddr_b (cs_raddr),
    .rdata_b (cs_rdata)
  );

endmodule

// File: rtl/idb_serial_id_chk.sv
module idb_serial_id_chk
  import idb_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          ready,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic          cs_we,
  input logic [AW-1:0] cs_addr
);

  // R8: the drive may only move while the sampled clock line is low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R3: no acknowledge before both checksums are placed
  a_r3_no_ack_before_sums: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ready);

  // R3: once placed, the checksums stay valid
  a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R7: host writes never reach a checksum slot or the fixed identity bytes
  a_r7_host_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> (32'(host_addr) != LO_SUM && 32'(host_addr) != HI_SUM &&
                 32'(host_addr) >= SERIAL_FIRST));

  // R4: the engine only writes checksum slots; the lower one only during start-up
  a_r4_sum_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |-> (32'(cs_addr) == HI_SUM || (32'(cs_addr) == LO_SUM && !ready)));

endmodule

bind idb_serial_id idb_serial_id_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .ready     (cs_ready),
  .host_we   (host_we),
  .host_addr (host_addr),
  .cs_we     (cs_we),
  .cs_addr   (cs_addr)
);

// File: tb/tb_idb_serial_id.sv
`timescale 1ns/1ps
module tb_idb_serial_id;

  localparam int HP = 10;  // SCL half period in system clocks

  logic clk;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_oe;
  wire  sda_w = m_sda & ~sda_oe;

  int vectors = 0;
  int fails   = 0;
  int r8_viol = 0;
  logic [7:0] exp_mem [128];

  idb_serial_id dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_w),
    .sda_oe (sda_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R8 monitor: drive must not move while SCL stays high
  logic p_scl, p_oe;
  always @(negedge clk) begin
    if (rst_n && p_scl && m_scl && (sda_oe !== p_oe)) r8_viol++;
    p_scl = m_scl;
    p_oe  = sda_oe;
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model built from R2, R3, R4, R7
  task automatic model_sums();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i <= 62; i++) s = s + exp_mem[i];
    exp_mem[63] = s;
    s = 8'h00;
    for (int i = 64; i <= 94; i++) s = s + exp_mem[i];
    exp_mem[95] = s;
  endtask

  task automatic model_init();
    for (int i = 0; i < 128; i++) begin
      if (i <= 62)                exp_mem[i] = 8'((7 * i + 3) % 256);
      else if (i >= 64 && i <= 94) exp_mem[i] = 8'(i) ^ 8'hA5;
      else                         exp_mem[i] = 8'h00;
    end
    model_sums();
  endtask

  task automatic model_write(int a, logic [7:0] d);
    if ((a >= 68 && a <= 91) || a >= 96) exp_mem[a] = d;
    model_sums();
  endtask

  // bus master primitives
  task automatic bus_start();
    m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP / 2);
    acked = !sda_w;
    tick(HP - HP / 2);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      m_scl = 1'b1; tick(HP / 2);
      b = {b[6:0], sda_w};
      tick(HP - HP / 2);
      m_scl = 1'b0;
    end
    m_sda = !give_ack; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0;
  endtask

  task automatic set_ptr(logic [7:0] a, string req);
    bit ak;
    bus_start();
    send_byte(8'hA0, ak); chk(req, ak, 1);
    send_byte(a, ak);     chk(req, ak, 1);
  endtask

  task automatic read_at(logic [7:0] a, int n, string req);
    bit ak;
    logic [7:0] b;
    set_ptr(a, req);
    bus_start();
    send_byte(8'hA1, ak); chk(req, ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(req, b, exp_mem[(int'(a & 8'h7F) + k) % 128]);
    end
    bus_stop();
  endtask

  task automatic write_at(int a, int n, logic [7:0] d0, logic [7:0] d1);
    bit ak;
    set_ptr(8'(a), "R7");
    for (int k = 0; k < n; k++) begin
      send_byte(k == 0 ? d0 : d1, ak);
      chk("R7", ak, 1);  // every data byte acknowledged
      model_write((a + k) % 128, k == 0 ? d0 : d1);
    end
    bus_stop();
  endtask

  // scenarios
  task automatic t_reset();
    tick(3);
    chk("R8", sda_oe, 0);
  endtask

  task automatic t_full_dump();
    bit ak;
    logic [7:0] b;
    set_ptr(8'h00, "R5");
    bus_start();
    send_byte(8'hA1, ak); chk("R1", ak, 1);
    for (int i = 0; i < 128; i++) begin
      recv_byte(i != 127, b);
      if (i == 63)      chk("R3", b, exp_mem[i]);
      else if (i == 95) chk("R4", b, exp_mem[i]);
      else              chk("R2", b, exp_mem[i]);
    end
    tick(4);
    chk("R6", sda_oe, 0);  // released after master NACK
    bus_stop();
  endtask

  task automatic t_wrap();
    read_at(8'd126, 4, "R6");  // 126,127,0,1
  endtask

  task automatic t_foreign();
    bit ak;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA2, ak); chk("R1", ak, 0);
    send_byte(8'hFF, ak); chk("R1", ak, 0);  // still silent
    bus_stop();
    bus_start();
    send_byte(8'hA1, ak); chk("R1", ak, 1);
    recv_byte(1'b0, b);
    chk("R5", b, exp_mem[2]);  // pointer kept from the wrap read
    bus_stop();
  endtask

  task automatic t_writes();
    write_at(70, 2, 8'h11, 8'h22);
    write_at(10, 1, 8'h33, 8'h00);   // fixed byte, ignored
    write_at(95, 1, 8'h00, 8'h00);   // checksum slot, ignored
    write_at(63, 1, 8'h7E, 8'h00);   // checksum slot, ignored
    write_at(126, 2, 8'h5C, 8'hC5);  // vendor area
    tick(100);
    read_at(8'd10, 1, "R7");
    read_at(8'd70, 2, "R7");
    read_at(8'd95, 1, "R4");
    read_at(8'd63, 1, "R3");
    read_at(8'd126, 2, "R7");
  endtask

  task automatic t_ptr_bit7();
    read_at(8'h80 | 8'd5, 1, "R5");  // bit 7 ignored: byte 5
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    p_scl = 1'b1;
    p_oe  = 1'b0;
    model_init();
    tick(5);
    rst_n = 1'b1;
    t_reset();
    tick(300);
    t_full_dump();
    t_wrap();
    t_foreign();
    t_writes();
    t_ptr_bit7();
    chk("R8", r8_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule